// File: doc/BRIEF.md
# Multi-Source Reset and Strap Controller

This block gathers six reset requests and turns each into its own set of reset actions. Two requests arrive as asynchronous active-low pins: a cold-reset pin and a warm-reset pin. Four arrive as synchronous levels: a software system-reset request (configuration bit 60), a software soft-reset request (configuration bit 58), a watchdog second timeout of system type and a watchdog second timeout of soft type. Each request selects a nested subset of these actions:

- re-latch the PLL ratio straps, restart the PLL and clear status bit 63;
- re-latch the remaining configuration straps;
- drive the external active-low reset output;
- reset the internal system bus and its agents.

Boot-strap values are read from a shared 12-bit address/data bus. They are captured at the moment the internal bus reset deasserts, and they are held until the next request that is allowed to re-sample them. The controller decodes four fields from the bus: the 100 MHz clock source, the divider select for each of two I/O clocks, and a 5-bit PLL ratio. The PLL, the watchdog counter and the dividers sit outside this block and take these outputs.

The external reset output and the bus reset each stay asserted for a set number of cycles after their last request goes away. When several requests are active together, the union of their actions is applied.

Top module: `rst_strap_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_rst` is 1 and `rst_out_n` is 0. After `rst_n` rises, `bus_rst` stays 1 for HOLD_CYCLES cycles. When it falls, every strap field is captured from `strap_ad`, as for a cold reset.
- R2: A low level on `cold_pin_n` is synchronized through two flops. When the resulting bus reset ends, the controller does three things. It captures every strap field, including the PLL ratio. It raises `pll_restart` and `status_clr` for exactly one cycle, in the cycle in which `bus_rst` first reads 0. It has also driven `rst_out_n` low during the episode.
- R3: A software system reset (`sw_sys_req`) re-captures the clock source and both divider fields. It leaves `pll_ratio` unchanged and produces no `pll_restart` pulse. It drives both `rst_out_n` and `bus_rst`.
- R4: A warm-pin assertion (`warm_pin_n` low, two-flop synchronized) or a system-type watchdog timeout (`wdt_sys_req`) asserts both `rst_out_n` and `bus_rst`. Neither request changes any strap field. Whenever `rst_out_n` is 0, `bus_rst` is 1.
- R5: A software soft reset (`sw_soft_req`) or a soft-type watchdog timeout (`wdt_soft_req`) asserts `bus_rst` only. With either request, `rst_out_n` stays 1 and every strap field keeps its value.
- R6: After the last request for an output drops, that output stays asserted for exactly HOLD_CYCLES further cycles, counted from the first clock edge without the request. A request that arrives during this window restarts it.
- R7: The strap fields decode `strap_ad` as follows. `clk_src_ref` is bit 1 (1 = reference input, 0 = divided PLL output). `iob0_div3` is bit 5 (1 = CPU/3, 0 = CPU/4). `iob1_div2` is bit 6 (1 = CPU/2, 0 = CPU/3). `pll_ratio` is bits 11..7. Bits 0 and 2..4 are ignored.
- R8: When requests overlap, the union of their actions is applied. A cold request together with a soft request still captures the PLL ratio. A soft request together with a warm request still drives `rst_out_n`.
- R9: Straps are sampled only at the clock edge where `bus_rst` falls. Changes on `strap_ad` at any other time leave the fields unchanged.
- R10: The two outputs are timed independently. `rst_out_n` returns to 1 HOLD_CYCLES after its own last request ends, even while a soft request keeps `bus_rst` asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; behaves like a cold reset |
| cold_pin_n | input | 1 | Asynchronous cold-reset pin, active low |
| warm_pin_n | input | 1 | Asynchronous warm-reset pin, active low |
| sw_sys_req | input | 1 | Software system-reset request (configuration bit 60) |
| sw_soft_req | input | 1 | Software soft-reset request (configuration bit 58) |
| wdt_sys_req | input | 1 | Watchdog second timeout, system type |
| wdt_soft_req | input | 1 | Watchdog second timeout, soft type |
| strap_ad | input | 12 | Shared address/data bus carrying strap levels |
| clk_src_ref | output | 1 | 1: 100 MHz clock taken from reference; 0: from divided PLL |
| iob0_div3 | output | 1 | 1: first I/O clock is CPU/3; 0: CPU/4 |
| iob1_div2 | output | 1 | 1: second I/O clock is CPU/2; 0: CPU/3 |
| pll_ratio | output | 5 | Latched PLL ratio field |
| pll_restart | output | 1 | One-cycle PLL restart pulse |
| status_clr | output | 1 | One-cycle pulse clearing status bit 63 |
| rst_out_n | output | 1 | External reset output, active low |
| bus_rst | output | 1 | Reset for the internal bus and its agents, active high |

## Verification
The bench builds the controller with HOLD_CYCLES set to 5. This keeps every stretch window short enough to count exactly from sample to sample. It also makes it practical to hold a soft request across the whole external-reset window, so the two stretchers can be seen running independently. With that width, each source can be pulsed alone and in overlapping pairs, and strap bus values can be changed inside and after the window, within a few hundred cycles.

// File: rtl/rsc_pkg.sv
// Package: shared types and strap field positions for the reset controller.
// Assumes a 12-bit strap bus with fixed field placement decoded by clock logic.
package rsc_pkg;

    localparam int STRAP_W    = 12;
    localparam int BIT_CLKSRC = 1;
    localparam int BIT_IOB0   = 5;
    localparam int BIT_IOB1   = 6;
    localparam int PLL_LSB    = 7;
    localparam int PLL_W      = 5;

    // One bit per synchronized reset request.
    typedef struct packed {
        logic cold;
        logic sw_sys;
        logic wdt_sys;
        logic warm;
        logic sw_soft;
        logic wdt_soft;
    } rsc_req_t;

    // Actions a request set asks for.
    typedef struct packed {
        logic pll;   // re-latch PLL ratio, restart PLL, clear status bit
        logic cfg;   // re-latch other straps
        logic ext;   // drive external reset output
        logic bus;   // reset internal bus and agents
    } rsc_act_t;

endpackage

// File: rtl/rsc_sync2.sv
// Module: two-flop synchronizer for a vector of asynchronous pins.
// Assumes bits are independent; RST_VAL is the idle level loaded on reset.
module rsc_sync2 #(
    parameter int              W       = 2,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Two-stage capture of the raw pins into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/rsc_classify.sv
// Module: maps active reset requests onto the nested action sets.
// Assumes all inputs are already synchronous and active high; purely combinational.
module rsc_classify
    import rsc_pkg::*;
(
    input  rsc_req_t req,
    output rsc_act_t act
);
    // Union of actions over all active requests.
    always_comb begin
        act.pll = req.cold;
        act.cfg = req.cold | req.sw_sys;
        act.ext = req.cold | req.sw_sys | req.wdt_sys | req.warm;
        act.bus = act.ext | req.sw_soft | req.wdt_soft;
    end
endmodule

// File: rtl/rsc_stretch.sv
// Module: holds an output asserted HOLD cycles past its last request.
// Assumes HOLD >= 1; active_q is registered; release_p marks the falling edge.
module rsc_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active_q,
    output logic release_p
);
    localparam int            CW     = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

    logic [CW-1:0] cnt;
    logic          busy;

    // Output is needed while a request is present or the window runs.
    assign busy      = req | (cnt != '0);
    // Asserted in the cycle whose closing edge drops active_q.
    assign release_p = active_q & ~busy;

    // Reload on request, count down otherwise, register the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= HOLD_C;
            active_q <= 1'b1;
        end else begin
            if (req)
                cnt <= HOLD_C;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            active_q <= busy;
        end
    end
endmodule

// File: rtl/rsc_strap_latch.sv
// Module: records which strap groups a reset episode may re-sample, and
// captures them from the bus when the internal bus reset deasserts.
// Assumes release_p is a single-cycle pulse from the bus stretcher.
module rsc_strap_latch
    import rsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  rsc_act_t           act,
    input  logic               release_p,
    input  logic [STRAP_W-1:0] strap_ad,
    output logic               clk_src_ref,
    output logic               iob0_div3,
    output logic               iob1_div2,
    output logic [PLL_W-1:0]   pll_ratio,
    output logic               pll_restart,
    output logic               status_clr
);
    logic pend_pll;
    logic pend_cfg;
    logic unused_straps;

    // Reserved and test positions carry no function here.
    assign unused_straps = ^{strap_ad[0], strap_ad[4:2]};

    // Track pending groups during an episode and capture them on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pll    <= 1'b1;
            pend_cfg    <= 1'b1;
            clk_src_ref <= 1'b0;
            iob0_div3   <= 1'b0;
            iob1_div2   <= 1'b0;
            pll_ratio   <= '0;
            pll_restart <= 1'b0;
            status_clr  <= 1'b0;
        end else begin
            pll_restart <= 1'b0;
            status_clr  <= 1'b0;
            if (release_p) begin
                if (pend_pll | act.pll) begin
                    pll_ratio   <= strap_ad[PLL_LSB +: PLL_W];
                    pll_restart <= 1'b1;
                    status_clr  <= 1'b1;
                end
                if (pend_cfg | act.cfg) begin
                    clk_src_ref <= strap_ad[BIT_CLKSRC];
                    iob0_div3   <= strap_ad[BIT_IOB0];
                    iob1_div2   <= strap_ad[BIT_IOB1];
                end
                pend_pll <= 1'b0;
                pend_cfg <= 1'b0;
            end else begin
                if (act.pll) pend_pll <= 1'b1;
                if (act.cfg) pend_cfg <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_strap_ctrl.sv
// Module: top of the multi-source reset and strap controller.
// Assumes pins are asynchronous and active low, software and watchdog
// requests are synchronous levels, and HOLD_CYCLES >= 1.
module rst_strap_ctrl
    import rsc_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cold_pin_n,
    input  logic               warm_pin_n,
    input  logic               sw_sys_req,
    input  logic               sw_soft_req,
    input  logic               wdt_sys_req,
    input  logic               wdt_soft_req,
    input  logic [STRAP_W-1:0] strap_ad,
    output logic               clk_src_ref,
    output logic               iob0_div3,
    output logic               iob1_div2,
    output logic [PLL_W-1:0]   pll_ratio,
    output logic               pll_restart,
    output logic               status_clr,
    output logic               rst_out_n,
    output logic               bus_rst
);
    localparam int N_STR = 2;   // index 0: external output, 1: internal bus

    logic [1:0]       pins_sync;
    rsc_req_t         req;
    rsc_act_t         act;
    logic [N_STR-1:0] str_req;
    logic [N_STR-1:0] str_active;
    logic [N_STR-1:0] str_release;

    rsc_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cold_pin_n, warm_pin_n}),
        .q_sync  (pins_sync)
    );

    // Collect all requests as active-high bits.
    always_comb begin
        req.cold     = ~pins_sync[1];
        req.warm     = ~pins_sync[0];
        req.sw_sys   = sw_sys_req;
        req.wdt_sys  = wdt_sys_req;
        req.sw_soft  = sw_soft_req;
        req.wdt_soft = wdt_soft_req;
    end

    rsc_classify u_classify (
        .req (req),
        .act (act)
    );

    assign str_req = {act.bus, act.ext};

    for (genvar g = 0; g < N_STR; g++) begin : g_str
        rsc_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (str_req[g]),
            .active_q  (str_active[g]),
            .release_p (str_release[g])
        );
    end

    assign rst_out_n = ~str_active[0];
    assign bus_rst   = str_active[1];

    rsc_strap_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .release_p   (str_release[1]),
        .strap_ad    (strap_ad),
        .clk_src_ref (clk_src_ref),
        .iob0_div3   (iob0_div3),
        .iob1_div2   (iob1_div2),
        .pll_ratio   (pll_ratio),
        .pll_restart (pll_restart),
        .status_clr  (status_clr)
    );
endmodule

// File: rtl/rsc_checker.sv
// Module: property checker for the reset controller, attached by bind.
// Assumes it sees only the top-level ports.
module rsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_src_ref,
    input logic       iob0_div3,
    input logic       iob1_div2,
    input logic [4:0] pll_ratio,
    input logic       pll_restart,
    input logic       rst_out_n,
    input logic       bus_rst
);
    assert_restart_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pll_restart |=> !pll_restart);

    assert_restart_on_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pll_restart |-> ($past(bus_rst) && !bus_rst));

    assert_ratio_needs_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_restart |-> $stable(pll_ratio));

    assert_ext_within_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> bus_rst);

    assert_straps_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(bus_rst) && !bus_rst) |-> $stable({clk_src_ref, iob0_div3, iob1_div2, pll_ratio}));
endmodule

bind rst_strap_ctrl rsc_checker u_rsc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_src_ref (clk_src_ref),
    .iob0_div3   (iob0_div3),
    .iob1_div2   (iob1_div2),
    .pll_ratio   (pll_ratio),
    .pll_restart (pll_restart),
    .rst_out_n   (rst_out_n),
    .bus_rst     (bus_rst)
);

// File: tb/rst_strap_ctrl_bench.sv
// Directed bench for the reset controller: one task per scenario.
module rst_strap_ctrl_bench;
    localparam int HOLD = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cold_pin_n = 1'b1;
    logic        warm_pin_n = 1'b1;
    logic        sw_sys_req = 1'b0;
    logic        sw_soft_req = 1'b0;
    logic        wdt_sys_req = 1'b0;
    logic        wdt_soft_req = 1'b0;
    logic [11:0] strap_ad = 12'h000;
    logic        clk_src_ref, iob0_div3, iob1_div2;
    logic [4:0]  pll_ratio;
    logic        pll_restart, status_clr, rst_out_n, bus_rst;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // Expected strap model
    logic       e_clk, e_iob0, e_iob1;
    logic [4:0] e_pll;

    // Observation results
    int obs_bus_hi;
    int obs_restarts;
    int obs_clears;
    bit obs_out_low;

    always #5 clk = ~clk;

    rst_strap_ctrl #(.HOLD_CYCLES(HOLD)) u_rst_strap_ctrl (
        .clk(clk), .rst_n(rst_n), .cold_pin_n(cold_pin_n), .warm_pin_n(warm_pin_n),
        .sw_sys_req(sw_sys_req), .sw_soft_req(sw_soft_req),
        .wdt_sys_req(wdt_sys_req), .wdt_soft_req(wdt_soft_req),
        .strap_ad(strap_ad), .clk_src_ref(clk_src_ref), .iob0_div3(iob0_div3),
        .iob1_div2(iob1_div2), .pll_ratio(pll_ratio), .pll_restart(pll_restart),
        .status_clr(status_clr), .rst_out_n(rst_out_n), .bus_rst(bus_rst)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_checks = n_checks + 1;
            n_fails  = n_fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic take_cfg(input logic [11:0] v);
        e_clk  = v[1];
        e_iob0 = v[5];
        e_iob1 = v[6];
    endtask

    task automatic take_pll(input logic [11:0] v);
        e_pll = v[11:7];
    endtask

    task automatic check_fields(input string tag);
        check(clk_src_ref == e_clk,  tag, "clk_src_ref", int'(clk_src_ref), int'(e_clk));
        check(iob0_div3   == e_iob0, tag, "iob0_div3",   int'(iob0_div3),   int'(e_iob0));
        check(iob1_div2   == e_iob1, tag, "iob1_div2",   int'(iob1_div2),   int'(e_iob1));
        check(pll_ratio   == e_pll,  tag, "pll_ratio",   int'(pll_ratio),   int'(e_pll));
    endtask

    // Sample a fixed window at falling edges after requests are dropped.
    task automatic observe(input int n);
        obs_bus_hi = 0; obs_restarts = 0; obs_clears = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_rst)     obs_bus_hi++;
            if (!rst_out_n)  obs_out_low = 1'b1;
            if (pll_restart) obs_restarts++;
            if (status_clr)  obs_clears++;
        end
    endtask

    // mask: 0 cold, 1 sw_sys, 2 wdt_sys, 3 warm, 4 sw_soft, 5 wdt_soft
    task automatic pulse(input logic [5:0] mask, input int n);
        @(negedge clk);
        obs_out_low  = 1'b0;
        cold_pin_n   = ~mask[0];
        sw_sys_req   = mask[1];
        wdt_sys_req  = mask[2];
        warm_pin_n   = ~mask[3];
        sw_soft_req  = mask[4];
        wdt_soft_req = mask[5];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst_out_n) obs_out_low = 1'b1;
        end
        cold_pin_n = 1'b1; warm_pin_n = 1'b1;
        sw_sys_req = 1'b0; wdt_sys_req = 1'b0;
        sw_soft_req = 1'b0; wdt_soft_req = 1'b0;
        observe(HOLD + 8);
    endtask

    task automatic t_reset;
        strap_ad = 12'hDA2;
        repeat (4) @(negedge clk);
        check(bus_rst == 1'b1,   "R1", "bus_rst in reset",   int'(bus_rst),   1);
        check(rst_out_n == 1'b0, "R1", "rst_out_n in reset", int'(rst_out_n), 0);
        rst_n = 1'b1;
        obs_out_low = 1'b0;
        observe(HOLD + 4);
        check(obs_bus_hi == HOLD, "R1", "bus_rst cycles after reset", obs_bus_hi, HOLD);
        take_cfg(12'hDA2); take_pll(12'hDA2);
        check_fields("R7");
        check(obs_restarts == 1, "R1", "restart pulses after reset", obs_restarts, 1);
    endtask

    task automatic t_cold;
        strap_ad = 12'h3C0;
        pulse(6'b000001, 3);
        take_cfg(12'h3C0); take_pll(12'h3C0);
        check_fields("R2");
        check(obs_restarts == 1, "R2", "pll_restart pulses", obs_restarts, 1);
        check(obs_clears == 1,   "R2", "status_clr pulses",  obs_clears, 1);
        check(obs_out_low,       "R2", "rst_out_n driven low", int'(obs_out_low), 1);
        strap_ad = 12'h000;
        repeat (3) @(negedge clk);
        check_fields("R9");
    endtask

    task automatic t_sw_sys;
        strap_ad = 12'hC62;
        pulse(6'b000010, 2);
        take_cfg(12'hC62);
        check_fields("R3");
        check(obs_restarts == 0, "R3", "no restart on sw system", obs_restarts, 0);
        check(obs_out_low,       "R3", "rst_out_n driven low", int'(obs_out_low), 1);
        check(obs_bus_hi == HOLD, "R6", "bus_rst stretch cycles", obs_bus_hi, HOLD);
    endtask

    task automatic t_sys_others;
        strap_ad = 12'hFFF;
        pulse(6'b001000, 3);
        check(obs_out_low, "R4", "warm drives rst_out_n", int'(obs_out_low), 1);
        check_fields("R4");
        pulse(6'b000100, 2);
        check(obs_out_low, "R4", "wdt sys drives rst_out_n", int'(obs_out_low), 1);
        check(obs_bus_hi == HOLD, "R6", "bus_rst stretch after wdt sys", obs_bus_hi, HOLD);
        check_fields("R4");
    endtask

    task automatic t_soft;
        strap_ad = 12'h000;
        pulse(6'b010000, 2);
        check(!obs_out_low, "R5", "sw soft leaves rst_out_n high", int'(obs_out_low), 0);
        check(obs_bus_hi == HOLD, "R5", "sw soft bus_rst cycles", obs_bus_hi, HOLD);
        check_fields("R5");
        pulse(6'b100000, 4);
        check(!obs_out_low, "R5", "wdt soft leaves rst_out_n high", int'(obs_out_low), 0);
        check(obs_bus_hi == HOLD, "R5", "wdt soft bus_rst cycles", obs_bus_hi, HOLD);
        check_fields("R5");
    endtask

    task automatic t_retrigger;
        @(negedge clk);
        sw_soft_req = 1'b1;
        @(negedge clk);
        sw_soft_req = 1'b0;
        repeat (HOLD - 2) @(negedge clk);
        sw_soft_req = 1'b1;
        @(negedge clk);
        sw_soft_req = 1'b0;
        observe(HOLD + 4);
        check(obs_bus_hi == HOLD, "R6", "window restarted by new request", obs_bus_hi, HOLD);
    endtask

    task automatic t_overlap;
        strap_ad = 12'h5A2;
        @(negedge clk);
        sw_soft_req = 1'b1;
        warm_pin_n  = 1'b0;
        repeat (3) @(negedge clk);
        check(rst_out_n == 1'b0, "R8", "warm with soft drives rst_out_n", int'(rst_out_n), 0);
        warm_pin_n = 1'b1;
        repeat (HOLD + 4) @(negedge clk);
        check(rst_out_n == 1'b1, "R10", "rst_out_n released under soft", int'(rst_out_n), 1);
        check(bus_rst == 1'b1,   "R10", "bus_rst held by soft",          int'(bus_rst),   1);
        sw_soft_req = 1'b0;
        observe(HOLD + 4);
        check_fields("R10");
        strap_ad = 12'h8A2;
        pulse(6'b010001, 3);
        take_cfg(12'h8A2); take_pll(12'h8A2);
        check_fields("R8");
        check(obs_restarts == 1, "R8", "cold with soft restarts pll", obs_restarts, 1);
    endtask

    initial begin
        e_clk = 1'b0; e_iob0 = 1'b0; e_iob1 = 1'b0; e_pll = 5'd0;
        t_reset();
        t_cold();
        t_sw_sys();
        t_sys_others();
        t_soft();
        t_retrigger();
        t_overlap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule